// File: doc/BRIEF.md
# Static Memory Zone Cycle Sequencer

This block runs one static memory bus cycle at a time for one of several address zones. Each zone has a configuration word that sets the cycle shape: internal wait cycles, hold cycles, data width, burst reads on narrow zones, single-cycle fast reads, and idle gaps when the bus changes zones. Zone 0 is the on-chip zone. The other zones are off-chip.

A request carries a zone, an address, a direction and a size (byte or 16-bit word). It is accepted while `ready_o` is high. The block then drives the zone's chip-select and the read or write strobe through the phases of the cycle. The phase order is: inserted idle, address, wait, data, hold. On a narrow zone a word access is split into two byte beats, and `lane_o` tells which byte is being moved. `done_o` marks the cycle in which the final data beat completes.

The configuration is sampled when a request is accepted. A configuration write made while a cycle is running therefore takes effect from the next request.

Top module: `static_zone_seq`

## Requirements
- R1: Each zone's configuration register resets to 16'h069F and reads back through `cfg_rdata_o` for the zone on `cfg_sel_i`. Bits 15:11 always read 0. The field layout is: wait count [2:0], hold count [4:3], burst enable [5], burst wait [6], 16-bit width [7], fast read [8], pre-idle [9], post-idle [10].
- R2: A single-beat normal access keeps `ready_o` low for 2 + wait + hold cycles. During the access only the addressed zone's `cs_o` bit is asserted.
- R3: A read in a zone with fast read set takes exactly one busy cycle per beat, and the wait, hold, burst and burst-wait fields have no effect. Writes never take the fast path.
- R4: A word access to an 8-bit zone that is not a burst read runs as two full beats, low byte first. Each beat has its own wait and hold cycles, and `lane_o` is 1 for the whole second beat.
- R5: A word read from an 8-bit zone with burst enabled takes 2 + wait + burst_wait + 1 + hold cycles. Here the second byte follows the first data cycle directly, after one extra wait when burst wait is set. When burst enable is clear, the burst-wait bit has no effect.
- R6: When the new request's zone differs from the previous request's zone, and the new zone is off-chip with pre-idle set, one idle cycle is inserted before the access. During an idle cycle `cs_o` is all zeros and both strobes are low.
- R7: When the previous access was to an off-chip zone with post-idle set, and the new request targets a different zone, one idle cycle is inserted before the new access.
- R8: The idle bits of the on-chip zone 0 never cause idle cycles. The first request after reset gets no idle cycle.
- R9: After reset `ready_o` is 1 and `cs_o` is 0. Every accepted request drops `ready_o` until it completes, and asserts `done_o` for exactly one cycle, in its final data cycle.
- R10: `rd_o` is asserted only for reads and `wr_o` only for writes. The two are never high together, and a strobe is never high without a chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | ZW | Zone selected for configuration read and write |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration of the selected zone |
| req_i | input | 1 | Request valid, accepted while ready_o is high |
| req_zone_i | input | ZW | Target zone |
| req_addr_i | input | AW | Access address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit access, 0 = byte |
| ready_o | output | 1 | Sequencer idle, request may be accepted |
| cs_o | output | NUM_ZONES | Chip-select, one bit per zone |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Address, bit 0 replaced by the byte lane on split accesses |
| lane_o | output | 1 | Byte lane of a split access (0 low, 1 high) |
| phase_o | output | 3 | Current phase: 0 idle, 1 post gap, 2 pre gap, 3 address, 4 wait, 5 data, 6 hold, 7 fast |
| done_o | output | 1 | Final data cycle of the request |

## Verification
The hardest case to reach from the ports is the inserted idle cycle. Whether it appears depends on three things at once: the previous request's zone, that zone's post-idle bit as it was when that request was accepted, and the pre-idle bit of the new zone, with the on-chip zone masking both. The bench keeps its own record of the previous zone and of the post-idle bit it latched. It interleaves requests to both zones with random rewrites of either zone's configuration between requests, so every combination of zone change and idle bits arises. It also covers narrow-zone burst, split and fast paths. Directed sequences first walk the on-chip masking and the move in each direction between zones.

// File: rtl/szs_pkg.sv
package szs_pkg;
  localparam int REG_W    = 16;
  localparam int CFG_BITS = 11;
  localparam logic [CFG_BITS-1:0] CFG_RST = 11'h69F;

  typedef struct packed {
    logic       post_idle;
    logic       pre_idle;
    logic       fast_rd;
    logic       width16;
    logic       burst_wait;
    logic       burst_en;
    logic [1:0] hold_n;
    logic [2:0] wait_n;
  } zcfg_t;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_GAP_POST = 3'd1,
    PH_GAP_PRE  = 3'd2,
    PH_ADDR     = 3'd3,
    PH_WAIT     = 3'd4,
    PH_DATA     = 3'd5,
    PH_HOLD     = 3'd6,
    PH_FAST     = 3'd7
  } phase_t;
endpackage

// File: rtl/szs_cfg_regs.sv
module szs_cfg_regs
  import szs_pkg::*;
#(
  parameter int NUM_ZONES = 2,
  parameter int ZW        = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ZW-1:0]               sel_i,
  input  logic [REG_W-1:0]            wdata_i,
  output zcfg_t [NUM_ZONES-1:0]       cfg_o,
  output logic [REG_W-1:0]            rdata_o
);
  logic [REG_W-CFG_BITS-1:0] unused_wdata;
  assign unused_wdata = wdata_i[REG_W-1:CFG_BITS];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    zcfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cfg_q <= zcfg_t'(CFG_RST);
      else if (we_i && sel_i == ZW'(z))     cfg_q <= zcfg_t'(wdata_i[CFG_BITS-1:0]);
    end
    assign cfg_o[z] = cfg_q;
  end

  // reserved upper bits are not stored and read as zero
  assign rdata_o = {{(REG_W-CFG_BITS){1'b0}}, cfg_o[sel_i]};
endmodule

// File: rtl/szs_seq.sv
module szs_seq
  import szs_pkg::*;
#(
  parameter int                    NUM_ZONES   = 2,
  parameter int                    ZW          = 1,
  parameter int                    AW          = 16,
  parameter logic [NUM_ZONES-1:0]  ONCHIP_MASK = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  zcfg_t [NUM_ZONES-1:0] cfg_i,
  input  logic                  req_i,
  input  logic [ZW-1:0]         req_zone_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic                  req_we_i,
  input  logic                  req_wide_i,
  output logic                  ready_o,
  output logic [NUM_ZONES-1:0]  cs_o,
  output logic                  rd_o,
  output logic                  wr_o,
  output logic [AW-1:0]         addr_o,
  output logic                  lane_o,
  output logic [2:0]            phase_o,
  output logic                  done_o
);
  phase_t st_q, st_d;
  logic [2:0] cnt_q, cnt_d;
  logic       lane_q, lane_d;

  logic [2:0]    wait_q;
  logic [1:0]    hold_q;
  logic          bwait_q, fast_q, we_q, split_q, burst_q, pre_q;
  logic [ZW-1:0] zone_q;
  logic [AW-1:0] addr_q;

  logic          prev_v_q, prev_post_q;
  logic [ZW-1:0] prev_zone_q;

  zcfg_t  nc;
  logic   acc, chg, new_off, post_need, pre_need, new_split;
  phase_t start_new, start_q;

  assign nc        = cfg_i[req_zone_i];
  assign acc       = req_i && (st_q == PH_IDLE);
  assign new_off   = !ONCHIP_MASK[req_zone_i];
  assign chg       = prev_v_q && (req_zone_i != prev_zone_q);
  assign post_need = chg && prev_post_q;
  assign pre_need  = chg && new_off && nc.pre_idle;
  assign new_split = req_wide_i && !nc.width16;
  assign start_new = (nc.fast_rd && !req_we_i) ? PH_FAST : PH_ADDR;
  assign start_q   = (fast_q && !we_q) ? PH_FAST : PH_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PH_IDLE;
      cnt_q       <= '0;
      lane_q      <= 1'b0;
      wait_q      <= '0;
      hold_q      <= '0;
      bwait_q     <= 1'b0;
      fast_q      <= 1'b0;
      we_q        <= 1'b0;
      split_q     <= 1'b0;
      burst_q     <= 1'b0;
      pre_q       <= 1'b0;
      zone_q      <= '0;
      addr_q      <= '0;
      prev_v_q    <= 1'b0;
      prev_post_q <= 1'b0;
      prev_zone_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lane_q <= lane_d;
      if (acc) begin
        wait_q      <= nc.wait_n;
        hold_q      <= nc.hold_n;
        bwait_q     <= nc.burst_wait;
        fast_q      <= nc.fast_rd;
        we_q        <= req_we_i;
        split_q     <= new_split;
        burst_q     <= new_split && !req_we_i && nc.burst_en && !nc.fast_rd;
        pre_q       <= pre_need;
        zone_q      <= req_zone_i;
        addr_q      <= req_addr_i;
        prev_v_q    <= 1'b1;
        prev_zone_q <= req_zone_i;
        prev_post_q <= new_off && nc.post_idle;
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lane_d = lane_q;
    unique case (st_q)
      PH_IDLE: if (acc) begin
        lane_d = 1'b0;
        if (post_need)     st_d = PH_GAP_POST;
        else if (pre_need) st_d = PH_GAP_PRE;
        else               st_d = start_new;
      end
      PH_GAP_POST: st_d = pre_q ? PH_GAP_PRE : start_q;
      PH_GAP_PRE:  st_d = start_q;
      PH_ADDR: begin
        if (wait_q != '0) begin st_d = PH_WAIT; cnt_d = wait_q; end
        else                    st_d = PH_DATA;
      end
      PH_WAIT: begin
        if (cnt_q <= 3'd1) st_d = PH_DATA;
        else               cnt_d = cnt_q - 3'd1;
      end
      PH_DATA: begin
        if (burst_q && !lane_q) begin
          lane_d = 1'b1;
          if (bwait_q) begin st_d = PH_WAIT; cnt_d = 3'd1; end
        end else if (hold_q != '0) begin
          st_d  = PH_HOLD;
          cnt_d = {1'b0, hold_q};
        end else if (split_q && !lane_q) begin
          lane_d = 1'b1;
          st_d   = PH_ADDR;
        end else begin
          st_d = PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (cnt_q <= 3'd1) begin
          if (split_q && !lane_q) begin lane_d = 1'b1; st_d = PH_ADDR; end
          else                          st_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 3'd1;
        end
      end
      PH_FAST: begin
        if (split_q && !lane_q) lane_d = 1'b1;
        else                    st_d = PH_IDLE;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  logic in_bus, strobe, final_beat;
  assign in_bus     = (st_q != PH_IDLE) && (st_q != PH_GAP_POST) && (st_q != PH_GAP_PRE);
  assign strobe     = (st_q == PH_ADDR) || (st_q == PH_WAIT) || (st_q == PH_DATA) || (st_q == PH_FAST);
  assign final_beat = !split_q || lane_q;

  assign ready_o = (st_q == PH_IDLE);
  assign cs_o    = in_bus ? (NUM_ZONES'(1) << zone_q) : '0;
  assign rd_o    = strobe && !we_q;
  assign wr_o    = strobe && we_q;
  assign lane_o  = lane_q;
  assign addr_o  = split_q ? {addr_q[AW-1:1], lane_q} : addr_q;
  assign phase_o = st_q;
  assign done_o  = ((st_q == PH_DATA) || (st_q == PH_FAST)) && final_beat;
endmodule

// File: rtl/static_zone_seq.sv
module static_zone_seq
  import szs_pkg::*;
#(
  parameter int                    NUM_ZONES   = 2,
  parameter int                    AW          = 16,
  parameter logic [NUM_ZONES-1:0]  ONCHIP_MASK = 1,
  localparam int                   ZW          = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ZW-1:0]        cfg_sel_i,
  input  logic [15:0]          cfg_wdata_i,
  output logic [15:0]          cfg_rdata_o,
  input  logic                 req_i,
  input  logic [ZW-1:0]        req_zone_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic                 req_we_i,
  input  logic                 req_wide_i,
  output logic                 ready_o,
  output logic [NUM_ZONES-1:0] cs_o,
  output logic                 rd_o,
  output logic                 wr_o,
  output logic [AW-1:0]        addr_o,
  output logic                 lane_o,
  output logic [2:0]           phase_o,
  output logic                 done_o
);
  zcfg_t [NUM_ZONES-1:0] cfg;

  szs_cfg_regs #(.NUM_ZONES(NUM_ZONES), .ZW(ZW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  szs_seq #(.NUM_ZONES(NUM_ZONES), .ZW(ZW), .AW(AW), .ONCHIP_MASK(ONCHIP_MASK)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .req_i      (req_i),
    .req_zone_i (req_zone_i),
    .req_addr_i (req_addr_i),
    .req_we_i   (req_we_i),
    .req_wide_i (req_wide_i),
    .ready_o    (ready_o),
    .cs_o       (cs_o),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .addr_o     (addr_o),
    .lane_o     (lane_o),
    .phase_o    (phase_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/static_zone_seq_chk.sv
module static_zone_seq_chk
  import szs_pkg::*;
#(
  parameter int                    NUM_ZONES   = 2,
  parameter logic [NUM_ZONES-1:0]  ONCHIP_MASK = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 ready_o,
  input logic                 done_o,
  input logic                 rd_o,
  input logic                 wr_o,
  input logic [NUM_ZONES-1:0] cs_o,
  input logic                 lane_o,
  input logic [2:0]           phase_o,
  input logic [15:0]          cfg_rdata_o
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[15:11] == 5'd0);

  a_r2_cs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  a_r3_fast_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_FAST) |-> (rd_o && !wr_o));

  a_r4_lane_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_o) |-> !ready_o);

  a_r6_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_o == PH_GAP_PRE) || (phase_o == PH_GAP_POST)) |-> (cs_o == '0 && !rd_o && !wr_o));

  a_r8_onchip_no_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_GAP_PRE) |=> ((cs_o & ONCHIP_MASK) == '0));

  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  a_r9_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);

  a_r10_rw_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  a_r10_strobe_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> (cs_o != '0));
endmodule

bind static_zone_seq static_zone_seq_chk #(.NUM_ZONES(NUM_ZONES), .ONCHIP_MASK(ONCHIP_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .cs_o        (cs_o),
  .lane_o      (lane_o),
  .phase_o     (phase_o),
  .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/static_zone_seq_test.sv
`timescale 1ns/1ps
module static_zone_seq_test;
  localparam int NZ = 2;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [0:0]    cfg_sel_i = '0;
  logic [15:0]   cfg_wdata_i = '0;
  logic [15:0]   cfg_rdata_o;
  logic          req_i = 1'b0;
  logic [0:0]    req_zone_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_we_i = 1'b0;
  logic          req_wide_i = 1'b0;
  logic          ready_o, rd_o, wr_o, lane_o, done_o;
  logic [NZ-1:0] cs_o;
  logic [AW-1:0] addr_o;
  logic [2:0]    phase_o;

  static_zone_seq #(.NUM_ZONES(NZ), .AW(AW), .ONCHIP_MASK(2'b01)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .req_i(req_i),
    .req_zone_i(req_zone_i), .req_addr_i(req_addr_i), .req_we_i(req_we_i),
    .req_wide_i(req_wide_i), .ready_o(ready_o), .cs_o(cs_o), .rd_o(rd_o),
    .wr_o(wr_o), .addr_o(addr_o), .lane_o(lane_o), .phase_o(phase_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [10:0] sh [NZ];
  bit pv = 0;
  int pz = 0;
  bit ppost = 0;

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(int z, logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 1'(z); cfg_wdata_i = d;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
    sh[z] = d[10:0];
  endtask

  task automatic cfg_rd(int z, string rq);
    @(negedge clk);
    cfg_sel_i = 1'(z);
    #1;
    chk(rq, int'(cfg_rdata_o), int'({5'd0, sh[z]}));
  endtask

  task automatic do_req(int z, bit we, bit wide);
    logic [10:0] c;
    int w, h, core, lanec, g_exp;
    bit ben, bw, w16, fr, pre, split, fast, burst, chg;
    int busy, gap, dn, ln, rdn, wrn, badcs;
    string tg, gtg;
    c = sh[z];
    w = int'(c[2:0]); h = int'(c[4:3]);
    ben = c[5]; bw = c[6]; w16 = c[7]; fr = c[8]; pre = c[9];
    split = wide && !w16;
    fast  = fr && !we;
    burst = split && !we && ben && !fast;
    if (fast)       begin core = split ? 2 : 1;      lanec = split ? 1 : 0;   tg = "R3"; end
    else if (burst) begin core = 3 + w + bw + h;    lanec = bw + 1 + h;      tg = "R5"; end
    else if (split) begin core = 2 * (2 + w + h);   lanec = 2 + w + h;       tg = "R4"; end
    else            begin core = 2 + w + h;         lanec = 0;               tg = (fr && we) ? "R3" : "R2"; end
    chg = pv && (z != pz);
    g_exp = 0;
    gtg = "R8";
    if (chg && ppost)         begin g_exp++; gtg = "R7"; end
    if (chg && z != 0 && pre) begin g_exp++; gtg = "R6"; end
    busy = 0; gap = 0; dn = 0; ln = 0; rdn = 0; wrn = 0; badcs = 0;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req_i = 1'b1; req_zone_i = 1'(z); req_we_i = we; req_wide_i = wide;
    req_addr_i = AW'($urandom) & ~AW'(1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      req_i = 1'b0;
      if (ready_o) break;
      busy++;
      if (cs_o == '0) gap++;
      else if (cs_o != NZ'(1 << z)) badcs++;
      if (done_o) dn++;
      if (lane_o) ln++;
      if (rd_o) rdn++;
      if (wr_o) wrn++;
    end
    chk({tg, " busy cycles"}, busy, core + g_exp);
    chk({gtg, " idle gap cycles"}, gap, g_exp);
    chk({tg, " high lane cycles"}, ln, lanec);
    chk("R9 done pulses", dn, 1);
    chk("R2 foreign chip-select", badcs, 0);
    chk("R10 read strobe seen", int'(rdn > 0), int'(!we));
    chk("R10 write strobe seen", int'(wrn > 0), int'(we));
    pv = 1; pz = z; ppost = (z != 0) && c[10];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    sh[0] = 11'h69F; sh[1] = 11'h69F;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", int'(ready_o), 1);
    chk("R9 cs after reset", int'(cs_o), 0);
    cfg_rd(0, "R1 zone0 reset value");
    cfg_rd(1, "R1 zone1 reset value");
    chk("R1 reset literal", int'(cfg_rdata_o), 16'h069F);
    cfg_wr(1, 16'hFFFF);
    cfg_rd(1, "R1 reserved bits read zero");
    cfg_wr(1, 16'h069F);

    // on-chip zone with idle bits set: wait 2, hold 1, 16-bit
    cfg_wr(0, 16'h068A);
    do_req(0, 0, 0);   // R8 first access, no gap; R2 5 cycles
    do_req(1, 0, 0);   // R6 pre gap, on-chip post ignored
    do_req(0, 1, 0);   // R7 post gap from zone 1, on-chip pre ignored
    cfg_wr(1, 16'h079F);
    do_req(1, 0, 0);   // R3 fast read with pre gap
    do_req(1, 0, 1);   // R3 fast, same zone
    do_req(1, 1, 0);   // R3 write ignores fast
    cfg_wr(1, 16'h0049);
    do_req(1, 0, 1);   // R4 split read, R5 burst wait ignored
    cfg_wr(1, 16'h0069);
    do_req(1, 0, 1);   // R5 burst with extra wait
    do_req(1, 1, 1);   // R4 write splits
    cfg_wr(1, 16'h0169);
    do_req(1, 0, 1);   // R3 fast split
    do_req(1, 0, 0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) begin
        int z;
        z = int'($urandom % 2);
        cfg_wr(z, 16'($urandom));
        cfg_rd(z, "R1 random readback");
      end
      do_req(int'($urandom % 2), 1'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule